// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

The block collects a vector of level-sensitive interrupt lines and presents two requests to a processor: a normal request and a fast request. Each request has its own enable mask over the same set of lines, and a line is forwarded to every request whose mask has it enabled. The two requests are evaluated separately, so one line can reach either request, both of them or neither.

A word-addressed register bus, with a write strobe and a combinational read path, sets and clears both masks and reads back raw and masked status. Line 0 can also be raised or dropped by software. The whole register set sits in the lowest sixteen words of an 8 MiB window. Controllers can be chained: a child's normal request drives line 26 of a parent, and the child's fast request is left unconnected.

The sampled line levels and both masks are registered. Both requests are combinational from that registered state, so they follow a register write or a newly sampled level without any further delay.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, the level vector and both masks are zero, both requests are low, and every register reads 0.
- R2: Level bits 1 to 31 take the value of the matching input line at every rising clock edge. Word offsets 1 and 9 both read the whole level vector.
- R3: The normal request is high exactly when (level AND normal mask) is non-zero. Word offset 0 reads that masked value.
- R4: The fast request is high exactly when (level AND fast mask) is non-zero, independent of the normal request. Word offset 8 reads that masked value.
- R5: A write to word offset 2 ORs the write data into the normal mask, and offset 2 reads the mask back. Each 1 written to word offset 3 clears the matching normal-mask bit.
- R6: A write to word offset 10 ORs the write data into the fast mask, and offset 10 reads the mask back. Each 1 written to word offset 11 clears the matching fast-mask bit.
- R7: A write to word offset 4 with data bit 0 set raises level bit 0. With bit 0 clear the write changes nothing.
- R8: A write to word offset 5 with data bit 0 set drops level bit 0. With bit 0 clear the write changes nothing.
- R9: Level bit 0 takes the value of input line 0 only on the edge after that line changes, and otherwise holds its value. A software set or clear in that same cycle takes priority over the line change.
- R10: Offsets that hold no register (6, 7, 12 to 15, any address with a bit above bit 3 set), and the write-only offsets 3, 4, 5 and 11, read 0. Writes to addresses outside offsets 0 to 15 change no state.
- R11: With a child controller's normal request wired to line 26, the parent sees level bit 26 one edge after the child's request rises. The parent's requests follow it through the parent's own masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Interrupt input lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word address within the window |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is line 0. Its level is held state that both software and an edge on the input line can change, and a soft clear and a rising input edge can land on the same clock edge. The stimulus toggles line 0, holds it high while a soft clear is issued, and then raises it in exactly the cycle that carries a soft-clear write. After each of these steps the raw level and the normal request are read back, which shows that the software action wins and that a steady high line does not bring the bit back. A second controller instance is chained into line 26 to exercise the cascade path.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_NORM = 0;
    localparam int CH_FAST = 1;

    localparam logic [2:0] SUB_STAT = 3'd0;
    localparam logic [2:0] SUB_RAW  = 3'd1;
    localparam logic [2:0] SUB_EN   = 3'd2;
    localparam logic [2:0] SUB_CLR  = 3'd3;

    localparam logic [3:0] OFF_SOFT_SET = 4'd4;
    localparam logic [3:0] OFF_SOFT_CLR = 4'd5;
endpackage

// File: rtl/intc_src_level.sv
module intc_src_level #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             soft_set,
    input  logic             soft_clr,
    output logic [N_SRC-1:0] level
);
    logic src0_q;
    logic lvl0_q;
    logic [N_SRC-1:1] upper_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else begin
            upper_q <= src[N_SRC-1:1];
        end
    end

    // Line 0 is event driven: software first, then a change on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src0_q <= 1'b0;
            lvl0_q <= 1'b0;
        end else begin
            src0_q <= src[0];
            if (soft_set) begin
                lvl0_q <= 1'b1;
            end else if (soft_clr) begin
                lvl0_q <= 1'b0;
            end else if (src[0] != src0_q) begin
                lvl0_q <= src[0];
            end
        end
    end

    assign level = {upper_q, lvl0_q};
endmodule

// File: rtl/intc_mask.sv
module intc_mask #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_bits,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] mask
);
    logic [N_SRC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q | set_bits) & ~clr_bits;
        end
    end

    assign mask = mask_q;
endmodule

// File: rtl/intc_csr.sv
module intc_csr
    import intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 21
) (
    input  logic                           wr,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [N_SRC-1:0]               wdata,
    input  logic [N_SRC-1:0]               level,
    input  logic [NUM_CH-1:0][N_SRC-1:0]   en,
    output logic [NUM_CH-1:0][N_SRC-1:0]   en_set,
    output logic [NUM_CH-1:0][N_SRC-1:0]   en_clr,
    output logic                           soft_set,
    output logic                           soft_clr,
    output logic [N_SRC-1:0]               rdata
);
    localparam int HI_W = ADDR_W - 4;

    logic       in_win;
    logic [3:0] off;
    logic [2:0] sub;
    logic       ch_sel;
    logic       wr_ok;

    assign in_win = (addr[ADDR_W-1:4] == HI_W'(0));
    assign off    = addr[3:0];
    assign sub    = off[2:0];
    assign ch_sel = off[3];
    assign wr_ok  = wr && in_win;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_wr
        always_comb begin
            en_set[c] = '0;
            en_clr[c] = '0;
            if (wr_ok && (ch_sel == c[0])) begin
                if (sub == SUB_EN)  en_set[c] = wdata;
                if (sub == SUB_CLR) en_clr[c] = wdata;
            end
        end
    end

    assign soft_set = wr_ok && (off == OFF_SOFT_SET) && wdata[0];
    assign soft_clr = wr_ok && (off == OFF_SOFT_CLR) && wdata[0];

    always_comb begin
        rdata = '0;
        if (in_win) begin
            unique case (sub)
                SUB_STAT: rdata = level & en[ch_sel];
                SUB_RAW:  rdata = level;
                SUB_EN:   rdata = en[ch_sel];
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
    import intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [N_SRC-1:0]  bus_wdata_i,
    output logic [N_SRC-1:0]  bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [N_SRC-1:0]             level_q;
    logic [NUM_CH-1:0][N_SRC-1:0] en_q;
    logic [NUM_CH-1:0][N_SRC-1:0] en_set;
    logic [NUM_CH-1:0][N_SRC-1:0] en_clr;
    logic [NUM_CH-1:0]            req;
    logic                         soft_set;
    logic                         soft_clr;

    intc_csr #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) csr_i (
        .wr       (bus_wr_i),
        .addr     (bus_addr_i),
        .wdata    (bus_wdata_i),
        .level    (level_q),
        .en       (en_q),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .soft_set (soft_set),
        .soft_clr (soft_clr),
        .rdata    (bus_rdata_o)
    );

    intc_src_level #(.N_SRC(N_SRC)) lvl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_i),
        .soft_set (soft_set),
        .soft_clr (soft_clr),
        .level    (level_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        intc_mask #(.N_SRC(N_SRC)) mask_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (en_set[c]),
            .clr_bits (en_clr[c]),
            .mask     (en_q[c])
        );
        assign req[c] = |(level_q & en_q[c]);
    end

    assign irq_o = req[CH_NORM];
    assign fiq_o = req[CH_FAST];
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [N_SRC-1:0]  wdata,
    input logic [N_SRC-1:0]  level,
    input logic [N_SRC-1:0]  norm_en,
    input logic [N_SRC-1:0]  fast_en
);
    logic hit_win;
    assign hit_win = (addr >> 4) == '0;

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> level[N_SRC-1:1] == $past(src[N_SRC-1:1])); // R2

    AST_NORM_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_win && addr[3:0] == 4'd2) |=> ((norm_en & $past(wdata)) == $past(wdata))); // R5

    AST_FAST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_win && addr[3:0] == 4'd11) |=> ((fast_en & $past(wdata)) == '0)); // R6

    AST_SOFT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_win && addr[3:0] == 4'd4 && wdata[0]) |=> level[0]); // R7

    AST_SOFT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_win && addr[3:0] == 4'd5 && wdata[0]) |=> !level[0]); // R8

    AST_OUT_WIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit_win) |=> ($stable(norm_en) && $stable(fast_en))); // R10
endmodule

bind irq_fiq_ctrl intc_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (src_i),
    .wr      (bus_wr_i),
    .addr    (bus_addr_i),
    .wdata   (bus_wdata_i),
    .level   (level_q),
    .norm_en (en_q[0]),
    .fast_en (en_q[1])
);

// File: tb/irq_fiq_ctrl_tb_top.sv
module irq_fiq_ctrl_tb_top;
    localparam int N = 32;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_tb = '0;
    logic [N-1:0]  dut_src;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic          irq, fiq;

    logic [N-1:0]  ch_src = '0;
    logic          ch_wr = 1'b0;
    logic [AW-1:0] ch_addr = '0;
    logic [N-1:0]  ch_wdata = '0;
    logic [N-1:0]  ch_rdata;
    logic          ch_irq, ch_fiq_unused;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;
        logic [N-1:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    assign dut_src = src_tb | (N'(ch_irq) << 26);

    irq_fiq_ctrl #(.N_SRC(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(dut_src),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq), .fiq_o(fiq)
    );

    irq_fiq_ctrl #(.N_SRC(N), .ADDR_W(AW)) child_i (
        .clk(clk), .rst_n(rst_n), .src_i(ch_src),
        .bus_wr_i(ch_wr), .bus_addr_i(ch_addr), .bus_wdata_i(ch_wdata),
        .bus_rdata_o(ch_rdata), .irq_o(ch_irq), .fiq_o(ch_fiq_unused)
    );

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [N-1:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = N'(irq);
                    default: act = N'(fiq);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int k, input logic [N-1:0] e, input string t);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.tag  = t;
        sb_q.push_back(it);
    endtask

    task automatic chk(input logic [AW-1:0] a, input logic [N-1:0] rd,
                       input logic ei, input logic ef, input string t);
        @(negedge clk);
        bus_addr = a;
        push(0, rd, t);
        push(1, N'(ei), t);
        push(2, N'(ef), t);
    endtask

    task automatic bw(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cw(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        ch_wr = 1'b1;
        ch_addr = a;
        ch_wdata = d;
        @(negedge clk);
        ch_wr = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(0, '0, 0, 0, "R1 masked normal");
        chk(1, '0, 0, 0, "R1 raw");
        chk(2, '0, 0, 0, "R1 normal mask");
        chk(10, '0, 0, 0, "R1 fast mask");

        // R2: raw level sampling
        @(negedge clk); src_tb = 32'hA5A5_0002;
        chk(1, 32'hA5A5_0002, 0, 0, "R2 raw off1");
        chk(9, 32'hA5A5_0002, 0, 0, "R2 raw off9");

        // R3 / R5: normal mask set and status
        bw(2, 32'h0000_0002);
        chk(2, 32'h0000_0002, 1, 0, "R5 mask set");
        chk(0, 32'h0000_0002, 1, 0, "R3 masked");
        bw(2, 32'h0100_0000);
        chk(2, 32'h0100_0002, 1, 0, "R5 mask OR");
        chk(0, 32'h0100_0002, 1, 0, "R3 masked two");
        bw(3, 32'h0000_0002);
        chk(2, 32'h0100_0000, 1, 0, "R5 partial clear");
        bw(3, 32'hFFFF_FFFF);
        chk(2, 32'h0000_0000, 0, 0, "R5 full clear");

        // R4 / R6: fast mask
        bw(10, 32'h8000_0000);
        chk(8, 32'h8000_0000, 0, 1, "R4 fast masked");
        chk(10, 32'h8000_0000, 0, 1, "R6 fast mask read");
        bw(11, 32'h8000_0000);
        chk(10, 32'h0000_0000, 0, 0, "R6 fast clear");

        // R7 / R8: software control of line 0
        @(negedge clk); src_tb = '0;
        bw(2, 32'h1);
        chk(1, 32'h0, 0, 0, "R7 baseline");
        bw(4, 32'hFFFF_FFFE);
        chk(1, 32'h0, 0, 0, "R7 bit0 clear ignored");
        bw(4, 32'h1);
        chk(1, 32'h1, 1, 0, "R7 soft set");
        chk(0, 32'h1, 1, 0, "R7 soft set masked");
        bw(5, 32'hFFFF_FFFE);
        chk(1, 32'h1, 1, 0, "R8 bit0 clear ignored");
        bw(5, 32'h1);
        chk(1, 32'h0, 0, 0, "R8 soft clear");

        // R9: line 0 edge behaviour and priority
        @(negedge clk); src_tb = 32'h1;
        chk(1, 32'h1, 1, 0, "R9 line rise");
        bw(5, 32'h1);
        chk(1, 32'h0, 0, 0, "R9 soft clear while line high");
        @(negedge clk); src_tb = 32'h0;
        chk(1, 32'h0, 0, 0, "R9 line fall");
        @(negedge clk);
        src_tb = 32'h1;
        bus_wr = 1'b1; bus_addr = 5; bus_wdata = 32'h1;
        @(negedge clk); bus_wr = 1'b0;
        chk(1, 32'h0, 0, 0, "R9 soft clear beats rise");
        chk(1, 32'h0, 0, 0, "R9 steady high holds");
        bw(4, 32'h1);
        chk(1, 32'h1, 1, 0, "R9 soft set again");
        @(negedge clk); src_tb = 32'h0;
        chk(1, 32'h0, 0, 0, "R9 fall after soft set");
        bw(3, 32'h1);

        // R10: holes and aliases
        @(negedge clk); src_tb = 32'h0000_00F0;
        bw(6, 32'hFFFF_FFFF);
        bw(12, 32'hFFFF_FFFF);
        bw(21'h10 | 21'd2, 32'hFFFF_FFFF);
        bw(21'h100000 | 21'd10, 32'hFFFF_FFFF);
        bw(21'h10 | 21'd4, 32'h1);
        chk(2, 32'h0, 0, 0, "R10 normal mask untouched");
        chk(10, 32'h0, 0, 0, "R10 fast mask untouched");
        chk(1, 32'h0000_00F0, 0, 0, "R10 alias soft set ignored");
        chk(6, 32'h0, 0, 0, "R10 hole reads 0");
        chk(3, 32'h0, 0, 0, "R10 write-only reads 0");
        chk(13, 32'h0, 0, 0, "R10 upper hole reads 0");
        chk(21'h100001, 32'h0, 0, 0, "R10 out of window reads 0");

        // R11: cascade into line 26
        @(negedge clk); src_tb = '0;
        cw(2, 32'h8);
        @(negedge clk); ch_src = 32'h8;
        @(negedge clk);
        chk(1, 32'h0400_0000, 0, 0, "R11 child seen on 26");
        bw(2, 32'h0400_0000);
        chk(0, 32'h0400_0000, 1, 0, "R11 parent request");
        @(negedge clk); ch_src = '0;
        @(negedge clk);
        chk(1, 32'h0, 0, 0, "R11 child drop");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule